// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block sits in front of a pipelined synchronous SRAM array. It samples the control pins on every rising clock edge and registers the cycle type that the array runs on the next clock. The cycle types are deselect, begin read, continue read, suspend read, begin write, continue write and suspend write. Along with the cycle type it registers which address the array should use: none, the externally presented address, the next burst address, or the current address held unchanged. The memory array and the burst counter are outside this block.

There are two address strobes. The processor-side strobe always starts a read, whatever the write controls say. The controller-side strobe starts either a read or a write, depending on the write term. When neither strobe is active, the advance input picks between stepping the burst and holding it. The block also registers per-byte write strobes. It gates an asynchronous output enable into a read-data drive signal. It sequences a sleep mode with fixed entry and recovery delays, and reports progress through a ready flag and an asleep flag.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: A strobe that is acted upon while the chip is not selected gives a deselect cycle on the next clock (cycle code 0, address select 0). The chip is selected when ce1_ni is low, ce2_i is high and ce3_ni is low. The processor strobe is acted upon only when ce1_ni is low. The controller strobe is acted upon whenever it is low and the processor strobe is not acted upon.
- R2: A low proc_strobe_ni with the chip selected gives a begin-read cycle (code 1) with address select 1 (external). This holds whatever the write controls are.
- R3: A low ctrl_strobe_ni, with the processor strobe not acted upon and the chip selected, gives a begin cycle with address select 1. The cycle is begin-write (code 4) when the write term is active and begin-read (code 1) when it is not.
- R4: With no strobe acted upon and a burst in progress (the current cycle code is not 0), a low adv_ni gives continue with address select 2 (next). The continue is code 5 when the write term is active, otherwise code 2. A high adv_ni gives suspend with address select 3 (current). The suspend is code 6 when the write term is active, otherwise code 3.
- R5: With no strobe acted upon and no burst in progress (current cycle code 0), the next cycle is deselect (code 0, address select 0).
- R6: The write term is active when gwrite_ni is low, or when bwrite_ni is low and at least one bit of byte_en_ni is low. In cycles with codes 4 to 6, byte_wstb_o is all ones if gwrite_ni was low. Otherwise bit i is high exactly when bwrite_ni and byte_en_ni[i] were both low. In every other cycle byte_wstb_o is zero.
- R7: rd_drive_o is high, combinationally, exactly when the registered cycle is a read (codes 1 to 3) and oe_ni is low. It is low in write and deselect cycles whatever oe_ni is.
- R8: If sleep_i is sampled high at an edge while ready_o is high, ready_o goes low from that edge and the cycle becomes deselect. asleep_o goes high one edge later. All strobes are ignored while ready_o is low.
- R9: If sleep_i is sampled low at an edge while asleep_o is high, asleep_o goes low from that edge and ready_o goes high one edge later. Strobes sampled at both of those edges are ignored, and the cycle stays deselect with no burst.
- R10: During reset, cycle_o and addr_sel_o are 0, byte_wstb_o is zero, rd_drive_o is low, ready_o is high and asleep_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce1_ni | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| proc_strobe_ni | input | 1 | Processor address strobe, active low |
| ctrl_strobe_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gwrite_ni | input | 1 | Global write, active low |
| bwrite_ni | input | 1 | Byte write enable, active low |
| byte_en_ni | input | NBYTES | Per-byte enables, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request, active high |
| cycle_o | output | 3 | Registered cycle code (0 deselect, 1 to 3 read begin/continue/suspend, 4 to 6 write begin/continue/suspend) |
| addr_sel_o | output | 2 | Address source: 0 none, 1 external, 2 next burst, 3 current |
| byte_wstb_o | output | NBYTES | Per-byte write strobes for the current cycle |
| rd_drive_o | output | 1 | Drive read data onto the bus |
| ready_o | output | 1 | Accepting new cycles |
| asleep_o | output | 1 | In sleep |

## Verification
The registered cycle code is the only memory of whether a burst is in progress. A wrong value shows up within one clock. A continue or suspend then appears where a deselect was due, or the reverse, and the address select and write strobes go wrong on the same cycle. A fault in the sleep sequencer shows up as ready_o or asleep_o changing one edge early or late. It can also show up as a strobe being obeyed on the edge right after wake-up. The bench compares every output with its own cycle model on every clock, so such faults are reported on the first cycle that differs.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE     = 3'd0,
    CYC_RD_BEGIN = 3'd1,
    CYC_RD_CONT  = 3'd2,
    CYC_RD_SUSP  = 3'd3,
    CYC_WR_BEGIN = 3'd4,
    CYC_WR_CONT  = 3'd5,
    CYC_WR_SUSP  = 3'd6
  } cyc_e;

  typedef enum logic [1:0] {
    ASEL_NONE = 2'd0,
    ASEL_EXT  = 2'd1,
    ASEL_NEXT = 2'd2,
    ASEL_CUR  = 2'd3
  } asel_e;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_ENTER = 2'd1,
    PWR_SLEEP = 2'd2,
    PWR_WAKE  = 2'd3
  } pwr_e;

  function automatic logic cyc_is_read(cyc_e c);
    return (c == CYC_RD_BEGIN) || (c == CYC_RD_CONT) || (c == CYC_RD_SUSP);
  endfunction

  function automatic logic cyc_is_write(cyc_e c);
    return (c == CYC_WR_BEGIN) || (c == CYC_WR_CONT) || (c == CYC_WR_SUSP);
  endfunction

endpackage

// File: rtl/sram_cyc_power.sv
module sram_cyc_power
  import sram_cyc_pkg::*;
#(
  parameter int unsigned ENTER_CYCLES = 2,
  parameter int unsigned WAKE_CYCLES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_i,
  output logic accept_o,
  output logic ready_o,
  output logic asleep_o
);
  localparam int unsigned MAXC = (ENTER_CYCLES > WAKE_CYCLES) ? ENTER_CYCLES : WAKE_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ENTER_LAST = CW'(ENTER_CYCLES - 1);
  localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYCLES - 1);
  localparam logic [CW-1:0] ONE        = CW'(1);

  pwr_e          state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PWR_RUN: if (sleep_i) begin
        state_d = PWR_ENTER;
        cnt_d   = ONE;
      end
      PWR_ENTER: begin
        if (cnt_q >= ENTER_LAST) state_d = PWR_SLEEP;
        else                     cnt_d   = cnt_q + ONE;
      end
      PWR_SLEEP: if (!sleep_i) begin
        state_d = PWR_WAKE;
        cnt_d   = ONE;
      end
      PWR_WAKE: begin
        if (cnt_q >= WAKE_LAST) state_d = PWR_RUN;
        else                    cnt_d   = cnt_q + ONE;
      end
      default: state_d = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PWR_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign accept_o = (state_q == PWR_RUN) && !sleep_i;
  assign ready_o  = (state_q == PWR_RUN);
  assign asleep_o = (state_q == PWR_SLEEP);

endmodule

// File: rtl/sram_cyc_wterm.sv
module sram_cyc_wterm #(
  parameter int unsigned NBYTES = 4
) (
  input  logic              gwrite_ni,
  input  logic              bwrite_ni,
  input  logic [NBYTES-1:0] byte_en_ni,
  output logic              wr_o,
  output logic [NBYTES-1:0] wstb_o
);
  logic [NBYTES-1:0] byte_hit;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign byte_hit[b] = !bwrite_ni && !byte_en_ni[b];
    assign wstb_o[b]   = !gwrite_ni || byte_hit[b];
  end

  assign wr_o = !gwrite_ni || (|byte_hit);

endmodule

// File: rtl/sram_cyc_decode.sv
module sram_cyc_decode
  import sram_cyc_pkg::*;
(
  input  logic  ce1_ni,
  input  logic  ce2_i,
  input  logic  ce3_ni,
  input  logic  proc_strobe_ni,
  input  logic  ctrl_strobe_ni,
  input  logic  adv_ni,
  input  logic  wr_i,
  input  logic  burst_i,
  output cyc_e  cyc_o,
  output asel_e asel_o
);
  logic sel, proc_act, ctrl_act;

  assign sel      = !ce1_ni && ce2_i && !ce3_ni;
  // processor strobe is masked by ce1 alone
  assign proc_act = !proc_strobe_ni && !ce1_ni;
  assign ctrl_act = !ctrl_strobe_ni && !proc_act;

  always_comb begin
    cyc_o  = CYC_IDLE;
    asel_o = ASEL_NONE;
    if (proc_act || ctrl_act) begin
      if (sel) begin
        asel_o = ASEL_EXT;
        cyc_o  = (ctrl_act && wr_i) ? CYC_WR_BEGIN : CYC_RD_BEGIN;
      end
    end else if (burst_i) begin
      if (!adv_ni) begin
        asel_o = ASEL_NEXT;
        cyc_o  = wr_i ? CYC_WR_CONT : CYC_RD_CONT;
      end else begin
        asel_o = ASEL_CUR;
        cyc_o  = wr_i ? CYC_WR_SUSP : CYC_RD_SUSP;
      end
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_cyc_pkg::*;
#(
  parameter int unsigned NBYTES       = 4,
  parameter int unsigned ENTER_CYCLES = 2,
  parameter int unsigned WAKE_CYCLES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              proc_strobe_ni,
  input  logic              ctrl_strobe_ni,
  input  logic              adv_ni,
  input  logic              gwrite_ni,
  input  logic              bwrite_ni,
  input  logic [NBYTES-1:0] byte_en_ni,
  input  logic              oe_ni,
  input  logic              sleep_i,
  output logic [2:0]        cycle_o,
  output logic [1:0]        addr_sel_o,
  output logic [NBYTES-1:0] byte_wstb_o,
  output logic              rd_drive_o,
  output logic              ready_o,
  output logic              asleep_o
);
  logic              accept, wr;
  logic [NBYTES-1:0] wstb_d;
  cyc_e              cyc_d, cyc_q;
  asel_e             asel_d, asel_q;
  logic [NBYTES-1:0] wstb_q;

  sram_cyc_power #(
    .ENTER_CYCLES(ENTER_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) i_power (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sleep_i (sleep_i),
    .accept_o(accept),
    .ready_o (ready_o),
    .asleep_o(asleep_o)
  );

  sram_cyc_wterm #(.NBYTES(NBYTES)) i_wterm (
    .gwrite_ni (gwrite_ni),
    .bwrite_ni (bwrite_ni),
    .byte_en_ni(byte_en_ni),
    .wr_o      (wr),
    .wstb_o    (wstb_d)
  );

  sram_cyc_decode i_decode (
    .ce1_ni        (ce1_ni),
    .ce2_i         (ce2_i),
    .ce3_ni        (ce3_ni),
    .proc_strobe_ni(proc_strobe_ni),
    .ctrl_strobe_ni(ctrl_strobe_ni),
    .adv_ni        (adv_ni),
    .wr_i          (wr),
    .burst_i       (cyc_q != CYC_IDLE),
    .cyc_o         (cyc_d),
    .asel_o        (asel_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= CYC_IDLE;
      asel_q <= ASEL_NONE;
      wstb_q <= '0;
    end else if (!accept) begin
      cyc_q  <= CYC_IDLE;
      asel_q <= ASEL_NONE;
      wstb_q <= '0;
    end else begin
      cyc_q  <= cyc_d;
      asel_q <= asel_d;
      wstb_q <= cyc_is_write(cyc_d) ? wstb_d : '0;
    end
  end

  assign cycle_o     = cyc_q;
  assign addr_sel_o  = asel_q;
  assign byte_wstb_o = wstb_q;
  // output enable is not registered
  assign rd_drive_o  = cyc_is_read(cyc_q) && !oe_ni;

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int unsigned NBYTES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce1_ni,
  input logic              ce2_i,
  input logic              ce3_ni,
  input logic              proc_strobe_ni,
  input logic              ctrl_strobe_ni,
  input logic              adv_ni,
  input logic              gwrite_ni,
  input logic              oe_ni,
  input logic              sleep_i,
  input logic [2:0]        cycle_o,
  input logic [1:0]        addr_sel_o,
  input logic [NBYTES-1:0] byte_wstb_o,
  input logic              rd_drive_o,
  input logic              ready_o,
  input logic              asleep_o
);
  logic sel, go;
  assign sel = !ce1_ni && ce2_i && !ce3_ni;
  assign go  = ready_o && !sleep_i;

  p_deselect_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !ce1_ni && !proc_strobe_ni && !sel |=> cycle_o == 3'd0 && addr_sel_o == 2'd0);

  p_proc_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && !proc_strobe_ni && sel |=> cycle_o == 3'd1 && addr_sel_o == 2'd1);

  p_ctrl_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && proc_strobe_ni && !ctrl_strobe_ni && sel && !gwrite_ni
    |=> cycle_o == 3'd4 && addr_sel_o == 2'd1);

  p_continue_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && proc_strobe_ni && ctrl_strobe_ni && !adv_ni && cycle_o != 3'd0
    |=> (cycle_o == 3'd2 || cycle_o == 3'd5) && addr_sel_o == 2'd2);

  p_no_burst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go && proc_strobe_ni && ctrl_strobe_ni && cycle_o == 3'd0 |=> cycle_o == 3'd0);

  p_strobe_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_o < 3'd4 |-> byte_wstb_o == '0);

  p_rd_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_drive_o |-> !oe_ni && cycle_o >= 3'd1 && cycle_o <= 3'd3);

  p_sleep_enter_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && sleep_i |=> !ready_o && cycle_o == 3'd0 && byte_wstb_o == '0);

  p_asleep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o |-> !ready_o);

  p_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(asleep_o) |-> !ready_o && cycle_o == 3'd0);

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.NBYTES(NBYTES)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ce1_ni        (ce1_ni),
  .ce2_i         (ce2_i),
  .ce3_ni        (ce3_ni),
  .proc_strobe_ni(proc_strobe_ni),
  .ctrl_strobe_ni(ctrl_strobe_ni),
  .adv_ni        (adv_ni),
  .gwrite_ni     (gwrite_ni),
  .oe_ni         (oe_ni),
  .sleep_i       (sleep_i),
  .cycle_o       (cycle_o),
  .addr_sel_o    (addr_sel_o),
  .byte_wstb_o   (byte_wstb_o),
  .rd_drive_o    (rd_drive_o),
  .ready_o       (ready_o),
  .asleep_o      (asleep_o)
);

// File: tb/test_sram_cycle_ctrl.sv
module test_sram_cycle_ctrl;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce1, ce2, ce3, ps, cs, adv, gw, bw, oe, slp;
  logic [NB-1:0] be;
  logic [2:0] cycle;
  logic [1:0] asel;
  logic [NB-1:0] wstb;
  logic rd_drive, ready, asleep;

  always #4 clk = ~clk;

  sram_cycle_ctrl #(.NBYTES(NB)) i_sram_cycle_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ce1_ni(ce1), .ce2_i(ce2), .ce3_ni(ce3),
    .proc_strobe_ni(ps), .ctrl_strobe_ni(cs), .adv_ni(adv), .gwrite_ni(gw),
    .bwrite_ni(bw), .byte_en_ni(be), .oe_ni(oe), .sleep_i(slp),
    .cycle_o(cycle), .addr_sel_o(asel), .byte_wstb_o(wstb), .rd_drive_o(rd_drive),
    .ready_o(ready), .asleep_o(asleep)
  );

  int n_chk = 0, n_bad = 0, wd = 0;

  // reference model: power mode 0 run, 1 entering, 2 asleep, 3 waking
  int m_pwr, m_cnt, e_cyc, e_asel, e_wstb, nc, na;
  string e_tag, p_tag;
  bit wr_t, sel_t;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwr = 0; m_cnt = 0; e_cyc = 0; e_asel = 0; e_wstb = 0;
      e_tag = "R10"; p_tag = "R10";
    end else if (m_pwr != 0 || slp) begin
      e_cyc = 0; e_asel = 0; e_wstb = 0;
      case (m_pwr)
        0: begin m_pwr = 1; m_cnt = 1; p_tag = "R8"; end
        1: begin if (m_cnt >= 1) m_pwr = 2; else m_cnt++; p_tag = "R8"; end
        2: begin if (!slp) begin m_pwr = 3; m_cnt = 1; p_tag = "R9"; end else p_tag = "R8"; end
        default: begin if (m_cnt >= 1) m_pwr = 0; else m_cnt++; p_tag = "R9"; end
      endcase
      e_tag = p_tag;
    end else begin
      wr_t  = (gw == 1'b0) || (bw == 1'b0 && be != 4'hF);
      sel_t = (ce1 == 1'b0) && (ce2 == 1'b1) && (ce3 == 1'b0);
      if (ps == 1'b0 && ce1 == 1'b0) begin
        if (sel_t) begin nc = 1; na = 1; e_tag = "R2"; end
        else begin nc = 0; na = 0; e_tag = "R1"; end
      end else if (cs == 1'b0) begin
        if (!sel_t) begin nc = 0; na = 0; e_tag = "R1"; end
        else begin nc = wr_t ? 4 : 1; na = 1; e_tag = "R3"; end
      end else if (e_cyc == 0) begin
        nc = 0; na = 0; e_tag = "R5";
      end else if (adv == 1'b0) begin
        nc = wr_t ? 5 : 2; na = 2; e_tag = "R4";
      end else begin
        nc = wr_t ? 6 : 3; na = 3; e_tag = "R4";
      end
      e_cyc = nc; e_asel = na;
      if (nc >= 4) e_wstb = (gw == 1'b0) ? 15 : ((bw == 1'b0) ? int'(~be) & 15 : 0);
      else e_wstb = 0;
      p_tag = "R8";
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(e_tag, "cycle", int'(cycle), e_cyc);
    chk(e_tag, "addr_sel", int'(asel), e_asel);
    chk("R6", "byte_wstb", int'(wstb), e_wstb);
    chk("R7", "rd_drive", int'(rd_drive), int'(e_cyc >= 1 && e_cyc <= 3 && oe == 1'b0));
    chk(p_tag, "ready", int'(ready), int'(m_pwr == 0));
    chk(p_tag, "asleep", int'(asleep), int'(m_pwr == 2));
  endtask

  task automatic step(bit c1, bit c2, bit c3, bit p, bit c, bit a,
                      bit g, bit b, bit [3:0] e, bit o, bit s);
    @(negedge clk);
    compare_all();
    ce1 = c1; ce2 = c2; ce3 = c3; ps = p; cs = c; adv = a;
    gw = g; bw = b; be = e; oe = o; slp = s;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd >= 200000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 200000 cycles", wd);
      finish_run();
    end
  end

  initial begin
    ce1 = 0; ce2 = 1; ce3 = 0; ps = 1; cs = 1; adv = 1;
    gw = 1; bw = 1; be = 4'hF; oe = 0; slp = 0;
    #3;
    // R10 reset values
    chk("R10", "cycle", int'(cycle), 0);
    chk("R10", "addr_sel", int'(asel), 0);
    chk("R10", "byte_wstb", int'(wstb), 0);
    chk("R10", "rd_drive", int'(rd_drive), 0);
    chk("R10", "ready", int'(ready), 1);
    chk("R10", "asleep", int'(asleep), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(0,1,0,1,1,1,1,1,4'hF,0,0); // R5 idle, no burst
    step(0,1,0,0,1,1,0,0,4'h0,0,0); // R2 proc read despite writes
    step(0,1,0,1,1,0,1,1,4'hF,0,0); // R4 continue read
    step(0,1,0,1,1,1,1,1,4'hF,0,0); // R4 suspend read
    step(0,1,0,1,1,0,0,1,4'hF,1,0); // R4 continue write, R7 oe high
    step(0,1,0,1,1,1,1,0,4'hA,0,0); // R4 suspend write, R6 bytes
    step(0,1,0,1,0,1,1,0,4'h6,0,0); // R3 ctrl write
    step(0,1,0,1,0,1,1,0,4'hF,0,0); // R3 ctrl read, R6 no bytes
    step(0,1,0,1,0,1,0,1,4'hF,0,0); // R3 global write
    step(0,0,0,0,1,1,1,1,4'hF,0,0); // R1 ce2 low
    step(0,1,0,1,1,0,1,1,4'hF,0,0); // R5 after deselect
    step(1,1,0,0,1,1,1,1,4'hF,0,0); // R5 proc masked by ce1
    step(0,1,0,0,1,1,1,1,4'hF,0,0); // R2
    step(1,1,0,0,1,0,1,1,4'hF,0,0); // R4 masked proc, burst continues
    step(1,1,0,1,0,1,1,1,4'hF,0,0); // R1 ce1 high ctrl
    step(0,1,0,0,1,1,1,1,4'hF,1,0); // R2, R7 oe high
    step(0,1,1,1,0,1,1,1,4'hF,0,0); // R1 ce3 high
    step(0,1,0,0,1,1,1,1,4'hF,0,0); // R2
    step(0,1,0,0,1,1,1,1,4'hF,0,1); // R8 sleep request
    for (int i = 0; i < 4; i++) step(0,1,0,0,0,0,0,0,4'h0,0,1); // R8 strobes ignored
    for (int i = 0; i < 3; i++) step(0,1,0,0,1,1,1,1,4'hF,0,0); // R9 wake
    step(0,1,0,1,1,0,1,1,4'hF,0,0);
    step(0,1,0,1,1,1,1,1,4'hF,0,1);
    step(0,1,0,1,1,1,1,1,4'hF,0,0); // R8 release during entry
    for (int i = 0; i < 5; i++) step(0,1,0,1,1,1,1,1,4'hF,0,0);
    for (int i = 0; i < 3000; i++) begin
      bit s;
      s = ($urandom_range(0, 9) == 0) ? ~slp : slp;
      step(bit'($urandom_range(0,5) == 0), bit'($urandom_range(0,5) != 0),
           bit'($urandom_range(0,5) == 0), bit'($urandom_range(0,2) == 0),
           bit'($urandom_range(0,2) == 0), bit'($urandom_range(0,1)),
           bit'($urandom_range(0,3) != 0), bit'($urandom_range(0,1)),
           4'($urandom_range(0,15)), bit'($urandom_range(0,1)), s);
    end
    step(0,1,0,1,1,1,1,1,4'hF,0,0);
    finish_run();
  end

endmodule